// File: doc/BRIEF.md
# Local Scan Port Configurator

This block sits beside a bridge TAP controller and decides how three local boundary-scan ports relate to the active scan chain. An 8-bit mode register picks which ports are in the chain. Any subset can be chosen: one port alone, or two or three chained in series behind the bridge's own selected register. One bit of the mode register overrides the rest and leaves only the bridge register in the path. For each port the block produces a TMS output, a TCK enable and a TDI feed. It also produces the composed serial TDO.

Each port has a small state machine that can park its local TAP in a stable state and later bring it back in step with the main TAP. The machine has four states:

- **SYNC**: the local TMS follows the main TMS.
- **ARMED**: a park was ordered but the port still follows the main TMS.
- **PARKED**: TMS is held at a constant value. TCK keeps running and the port is out of the chain.
- **REJOIN**: TMS is held low until the main TAP reaches Run-Test/Idle.

The transitions are:

- SYNC→ARMED on a park command to a selected port.
- ARMED→PARKED on an Exit1-to-Update step of the main TAP.
- PARKED→REJOIN on an unpark command.
- REJOIN→SYNC when the main TAP is in Run-Test/Idle.
- Every state→SYNC when the main TAP is in Test-Logic-Reset.

The main TAP state arrives on `tap_state` with this encoding:

| State | Code |
|---|---|
| Exit1-DR | 0x1 |
| Pause-DR | 0x3 |
| Update-DR | 0x5 |
| Select-DR | 0x7 |
| Exit1-IR | 0x9 |
| Pause-IR | 0xB |
| Run-Test/Idle | 0xC |
| Update-IR | 0xD |
| Test-Logic-Reset | 0xF |

Every other 4-bit value is one of the remaining TAP states.

Top module: `lsp_config`

## Requirements
- R1: After `rst_n` low, or after any rising edge with `tap_state` = 0xF, the mode register is 0x00 and all ports are in SYNC. This gives `lp_tck_en` = 000, `tdo_out` = `bridge_so` and `lp_tms` = `tms_in` on every port.
- R2: Mode bits [2:0] form a port mask: bit 0 is port 1 (index 0), bit 1 is port 2, bit 2 is port 3. A selected port in SYNC or ARMED has its TCK enable high and is in the serial path. An unselected port in SYNC has TCK enable low.
- R3: The serial order is `bridge_so` → port 1 → port 2 → port 3 → `tdo_out`, skipping ports not in the path. The latency from `bridge_so` to `tdo_out` equals the summed lengths of the ports in the path.
- R4: Mode bit 3 has no effect on the configuration.
- R5: When mode bit 4 is 1, no local port is in the path and `tdo_out` equals `bridge_so`, whatever bits [3:0] hold.
- R6: `mode_load` high at a rising edge writes `mode_din` into the mode register.
- R7: `park_cmd` high at a rising edge moves every selected SYNC port to ARMED and records `park_tgt`. An ARMED port's TMS still follows `tms_in`.
- R8: An ARMED port becomes PARKED only at a rising edge where `tap_state` is Update-DR (0x5) or Update-IR (0xD) and the previous edge saw Exit1-DR (0x1) or Exit1-IR (0x9).
- R9: A PARKED port holds TMS at 0 for targets 0 (Run-Test/Idle), 1 (Pause-DR) and 2 (Pause-IR), and at 1 for target 3 (Test-Logic-Reset). It keeps TCK enabled and leaves the serial path.
- R10: `unpark_cmd` high at a rising edge moves every PARKED port to REJOIN. A REJOIN port holds TMS at 0 with TCK enabled, including when the main TAP goes from Update-IR to Select-DR.
- R11: A REJOIN port returns to SYNC only at a rising edge where `tap_state` is Run-Test/Idle (0xC).
- R12: A SYNC port drives its `lp_tms` bit equal to `tms_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock of the bridge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_state | input | 4 | Current state of the main TAP controller |
| tms_in | input | 1 | Main TMS from the backplane |
| mode_load | input | 1 | Write strobe for the mode register |
| mode_din | input | 8 | Value written into the mode register |
| park_cmd | input | 1 | Park order for selected ports |
| park_tgt | input | 2 | Stable state to park in (0 idle, 1 pause-DR, 2 pause-IR, 3 reset) |
| unpark_cmd | input | 1 | Release order for parked ports |
| bridge_so | input | 1 | Serial output of the bridge's selected register |
| lp_tdo | input | 3 | Serial returns of the local ports |
| lp_tdi | output | 3 | Serial feeds to the local ports |
| lp_tms | output | 3 | TMS per local port |
| lp_tck_en | output | 3 | TCK enable per local port |
| tdo_out | output | 1 | Composed serial output toward the backplane |

## Verification
The bench models the three local ports as shift registers of lengths 1, 2 and 4. It shifts a fixed 16-bit pattern from `bridge_so` and compares `tdo_out` against a delayed copy.

- **All eight mask codes:** the latencies 0 to 7 are all distinct, so a wrong port, a wrong order or a missing bypass each show up as a wrong delay.
- **Codes with bit 3 set and codes with bit 4 set:** these separate the ignored bit from the override bit.
- **Park and unpark sequences:** these drive the main TAP through Exit2-to-Update and Exit1-to-Update paths and through Update-IR to Select-DR to Run-Test/Idle. They show whether parking and rejoining wait for the right transitions, and which TMS value each port holds.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [3:0] {
        TS_EXIT2_DR   = 4'h0,
        TS_EXIT1_DR   = 4'h1,
        TS_SHIFT_DR   = 4'h2,
        TS_PAUSE_DR   = 4'h3,
        TS_SELECT_IR  = 4'h4,
        TS_UPDATE_DR  = 4'h5,
        TS_CAPTURE_DR = 4'h6,
        TS_SELECT_DR  = 4'h7,
        TS_EXIT2_IR   = 4'h8,
        TS_EXIT1_IR   = 4'h9,
        TS_SHIFT_IR   = 4'hA,
        TS_PAUSE_IR   = 4'hB,
        TS_RUN_IDLE   = 4'hC,
        TS_UPDATE_IR  = 4'hD,
        TS_CAPTURE_IR = 4'hE,
        TS_TEST_RESET = 4'hF
    } tap_st_e;

    typedef enum logic [1:0] {
        PS_SYNC   = 2'd0,
        PS_ARMED  = 2'd1,
        PS_PARKED = 2'd2,
        PS_REJOIN = 2'd3
    } port_st_e;

    typedef enum logic [1:0] {
        PK_IDLE     = 2'd0,
        PK_PAUSE_DR = 2'd1,
        PK_PAUSE_IR = 2'd2,
        PK_RESET    = 2'd3
    } park_tgt_e;

    function automatic logic park_hold_level(park_tgt_e tgt);
        return (tgt == PK_RESET);
    endfunction

endpackage

// File: rtl/lsp_mode_reg.sv
module lsp_mode_reg
    import lsp_pkg::*;
#(
    parameter int MODE_W    = 8,
    parameter int NPORT     = 3,
    parameter int FORCE_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tlr,
    input  logic              load,
    input  logic [MODE_W-1:0] din,
    output logic [NPORT-1:0]  sel
);

    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (tlr) begin
            mode_q <= '0;
        end else if (load) begin
            mode_q <= din;
        end
    end

    always_comb begin
        if (mode_q[FORCE_BIT]) begin
            sel = '0;
        end else begin
            sel = mode_q[NPORT-1:0];
        end
    end

endmodule

// File: rtl/lsp_port_fsm.sv
module lsp_port_fsm
    import lsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tlr,
    input  logic      sel,
    input  logic      park_go,
    input  park_tgt_e park_tgt,
    input  logic      unpark_go,
    input  logic      upd_after_exit1,
    input  logic      in_idle,
    input  logic      tms_in,
    output port_st_e  st,
    output logic      tms_o,
    output logic      tck_en_o,
    output logic      in_chain_o
);

    port_st_e  st_q, st_d;
    park_tgt_e tgt_q, tgt_d;

    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        if (tlr) begin
            st_d = PS_SYNC;
        end else begin
            unique case (st_q)
                PS_SYNC: begin
                    if (park_go && sel) begin
                        st_d  = PS_ARMED;
                        tgt_d = park_tgt;
                    end
                end
                PS_ARMED: begin
                    if (upd_after_exit1) begin
                        st_d = PS_PARKED;
                    end
                end
                PS_PARKED: begin
                    if (unpark_go) begin
                        st_d = PS_REJOIN;
                    end
                end
                PS_REJOIN: begin
                    if (in_idle) begin
                        st_d = PS_SYNC;
                    end
                end
                default: st_d = PS_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_SYNC;
            tgt_q <= PK_IDLE;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    always_comb begin
        tms_o      = tms_in;
        tck_en_o   = 1'b1;
        in_chain_o = 1'b0;
        unique case (st_q)
            PS_SYNC: begin
                tms_o      = tms_in;
                tck_en_o   = sel;
                in_chain_o = sel;
            end
            PS_ARMED: begin
                tms_o      = tms_in;
                tck_en_o   = 1'b1;
                in_chain_o = sel;
            end
            PS_PARKED: begin
                tms_o      = park_hold_level(tgt_q);
                tck_en_o   = 1'b1;
                in_chain_o = 1'b0;
            end
            PS_REJOIN: begin
                tms_o      = 1'b0;
                tck_en_o   = 1'b1;
                in_chain_o = 1'b0;
            end
            default: begin
                tms_o      = tms_in;
                tck_en_o   = 1'b0;
                in_chain_o = 1'b0;
            end
        endcase
    end

    assign st = st_q;

endmodule

// File: rtl/lsp_chain_mux.sv
module lsp_chain_mux #(
    parameter int NPORT = 3
) (
    input  logic             bridge_so,
    input  logic [NPORT-1:0] port_tdo,
    input  logic [NPORT-1:0] in_chain,
    output logic [NPORT-1:0] port_tdi,
    output logic             tdo
);

    logic [NPORT:0] node;

    assign node[0] = bridge_so;

    for (genvar i = 0; i < NPORT; i++) begin : g_seg
        assign port_tdi[i] = node[i];
        assign node[i+1]   = in_chain[i] ? port_tdo[i] : node[i];
    end

    assign tdo = node[NPORT];

endmodule

// File: rtl/lsp_config.sv
module lsp_config
    import lsp_pkg::*;
#(
    parameter int NPORT     = 3,
    parameter int MODE_W    = 8,
    parameter int FORCE_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        tap_state,
    input  logic              tms_in,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              park_cmd,
    input  logic [1:0]        park_tgt,
    input  logic              unpark_cmd,
    input  logic              bridge_so,
    input  logic [NPORT-1:0]  lp_tdo,
    output logic [NPORT-1:0]  lp_tdi,
    output logic [NPORT-1:0]  lp_tms,
    output logic [NPORT-1:0]  lp_tck_en,
    output logic              tdo_out
);

    tap_st_e                cur_st;
    tap_st_e                prev_st;
    logic                   tlr;
    logic                   upd_after_exit1;
    logic                   in_idle;
    logic [NPORT-1:0]       sel;
    logic [NPORT-1:0]       in_chain;
    port_st_e [NPORT-1:0]   port_st;

    assign cur_st  = tap_st_e'(tap_state);
    assign tlr     = (cur_st == TS_TEST_RESET);
    assign in_idle = (cur_st == TS_RUN_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_st <= TS_TEST_RESET;
        end else begin
            prev_st <= cur_st;
        end
    end

    assign upd_after_exit1 =
        ((cur_st == TS_UPDATE_DR) || (cur_st == TS_UPDATE_IR)) &&
        ((prev_st == TS_EXIT1_DR) || (prev_st == TS_EXIT1_IR));

    lsp_mode_reg #(
        .MODE_W    (MODE_W),
        .NPORT     (NPORT),
        .FORCE_BIT (FORCE_BIT)
    ) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .tlr   (tlr),
        .load  (mode_load),
        .din   (mode_din),
        .sel   (sel)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        lsp_port_fsm u_fsm (
            .clk             (clk),
            .rst_n           (rst_n),
            .tlr             (tlr),
            .sel             (sel[i]),
            .park_go         (park_cmd),
            .park_tgt        (park_tgt_e'(park_tgt)),
            .unpark_go       (unpark_cmd),
            .upd_after_exit1 (upd_after_exit1),
            .in_idle         (in_idle),
            .tms_in          (tms_in),
            .st              (port_st[i]),
            .tms_o           (lp_tms[i]),
            .tck_en_o        (lp_tck_en[i]),
            .in_chain_o      (in_chain[i])
        );
    end

    lsp_chain_mux #(
        .NPORT (NPORT)
    ) u_chain (
        .bridge_so (bridge_so),
        .port_tdo  (lp_tdo),
        .in_chain  (in_chain),
        .port_tdi  (lp_tdi),
        .tdo       (tdo_out)
    );

endmodule

// File: rtl/lsp_config_chk.sv
module lsp_config_chk
    import lsp_pkg::*;
#(
    parameter int NPORT = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           tap_state,
    input logic                 bridge_so,
    input logic [NPORT-1:0]     lp_tms,
    input logic [NPORT-1:0]     lp_tck_en,
    input logic                 tdo_out,
    input port_st_e [NPORT-1:0] port_st
);

    AST_RESET_STATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_state == 4'hF) |=> (lp_tck_en == '0)) else $error("reset state"); // R1

    AST_NO_PORT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_tck_en == '0) |-> (tdo_out == bridge_so)) else $error("pass"); // R5

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        AST_PARK_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_st[i] == PS_PARKED) |->
                ($past(tap_state) == 4'h5 || $past(tap_state) == 4'hD)) else $error("park"); // R8

        AST_PARKED_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (port_st[i] == PS_PARKED) |-> lp_tck_en[i]) else $error("parked tck"); // R9

        AST_REJOIN_TMS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (port_st[i] == PS_REJOIN) |-> !lp_tms[i]) else $error("rejoin tms"); // R10

        AST_REJOIN_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (port_st[i] == PS_REJOIN && tap_state != 4'hC && tap_state != 4'hF)
                |=> (port_st[i] == PS_REJOIN)) else $error("rejoin wait"); // R11
    end

endmodule

bind lsp_config lsp_config_chk #(.NPORT(NPORT)) u_lsp_config_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_state (tap_state),
    .bridge_so (bridge_so),
    .lp_tms    (lp_tms),
    .lp_tck_en (lp_tck_en),
    .tdo_out   (tdo_out),
    .port_st   (port_st)
);

// File: tb/lsp_config_bench.sv
module lsp_config_bench;

    localparam logic [3:0] T_EXIT2_DR  = 4'h0;
    localparam logic [3:0] T_EXIT1_DR  = 4'h1;
    localparam logic [3:0] T_UPDATE_DR = 4'h5;
    localparam logic [3:0] T_SELECT_DR = 4'h7;
    localparam logic [3:0] T_EXIT1_IR  = 4'h9;
    localparam logic [3:0] T_RUN_IDLE  = 4'hC;
    localparam logic [3:0] T_UPDATE_IR = 4'hD;
    localparam logic [3:0] T_RESET     = 4'hF;
    localparam logic [15:0] PATTERN    = 16'hB4E7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tap_state = T_RUN_IDLE;
    logic       tms_in = 1'b0;
    logic       mode_load = 1'b0;
    logic [7:0] mode_din = 8'h00;
    logic       park_cmd = 1'b0;
    logic [1:0] park_tgt = 2'd0;
    logic       unpark_cmd = 1'b0;
    logic       bridge_so = 1'b0;
    logic [2:0] lp_tdo;
    logic [2:0] lp_tdi;
    logic [2:0] lp_tms;
    logic [2:0] lp_tck_en;
    logic       tdo_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lsp_config u_lsp_config (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap_state  (tap_state),
        .tms_in     (tms_in),
        .mode_load  (mode_load),
        .mode_din   (mode_din),
        .park_cmd   (park_cmd),
        .park_tgt   (park_tgt),
        .unpark_cmd (unpark_cmd),
        .bridge_so  (bridge_so),
        .lp_tdo     (lp_tdo),
        .lp_tdi     (lp_tdi),
        .lp_tms     (lp_tms),
        .lp_tck_en  (lp_tck_en),
        .tdo_out    (tdo_out)
    );

    // Local port models: shift registers of length 1, 2 and 4
    logic       sr0 = 1'b0;
    logic [1:0] sr1 = '0;
    logic [3:0] sr2 = '0;
    always_ff @(posedge clk) begin
        if (lp_tck_en[0]) sr0 <= lp_tdi[0];
        if (lp_tck_en[1]) sr1 <= {sr1[0], lp_tdi[1]};
        if (lp_tck_en[2]) sr2 <= {sr2[2:0], lp_tdi[2]};
    end
    assign lp_tdo = {sr2[3], sr1[1], sr0};

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard
    bit   exp_q[$];
    bit   mon_on = 1'b0;
    int   mon_lat = 0;
    string mon_req = "";

    always @(negedge clk) begin
        #2;
        if (mon_on && exp_q.size() > mon_lat) begin
            bit e;
            e = exp_q.pop_front();
            check(mon_req, "serial tdo", {7'd0, tdo_out}, {7'd0, e});
        end
    end

    task automatic load_mode(input logic [7:0] v);
        @(negedge clk);
        mode_load = 1'b1;
        mode_din  = v;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic run_path(input logic [7:0] code, input int lat, input string req);
        load_mode(code);
        exp_q.delete();
        mon_lat = lat;
        mon_req = req;
        mon_on  = 1'b1;
        for (int k = 0; k < 24; k++) begin
            if (k > 0) @(negedge clk);
            bridge_so = PATTERN[k % 16];
            exp_q.push_back(PATTERN[k % 16]);
        end
        @(negedge clk);
        mon_on = 1'b0;
        #3;
        exp_q.delete();
    endtask

    task automatic step(input logic [3:0] st);
        @(negedge clk);
        tap_state = st;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        tms_in = 1'b1; bridge_so = 1'b1; #1;
        check("R1", "tck_en after reset", {5'd0, lp_tck_en}, 8'h00);
        check("R1", "tdo pass after reset", {7'd0, tdo_out}, 8'h01);
        check("R12", "tms follow after reset", {5'd0, lp_tms}, 8'h07);
        tms_in = 1'b0; #1;
        check("R12", "tms follow low", {5'd0, lp_tms}, 8'h00);

        // R2 R3 R6: every mask code
        for (int c = 0; c < 8; c++) begin
            run_path(8'(c), c, "R3");
        end
        load_mode(8'h05);
        @(negedge clk); #1;
        check("R2", "tck_en for mask 101", {5'd0, lp_tck_en}, 8'h05);
        run_path(8'h0D, 5, "R4");
        run_path(8'h08, 0, "R4");
        run_path(8'h17, 0, "R5");
        run_path(8'h1F, 0, "R5");
        @(negedge clk); #1;
        check("R5", "tck_en with override", {5'd0, lp_tck_en}, 8'h00);
        run_path(8'h03, 3, "R6");

        // Park port 1 in run-idle
        load_mode(8'h01);
        @(negedge clk);
        tap_state = T_UPDATE_IR; park_cmd = 1'b1; park_tgt = 2'd0; tms_in = 1'b1;
        @(negedge clk);
        park_cmd = 1'b0; tap_state = T_EXIT2_DR; #1;
        check("R7", "armed tms follows", {7'd0, lp_tms[0]}, 8'h01);
        step(T_UPDATE_DR);
        step(T_EXIT1_DR); #1;
        check("R8", "no park after exit2-update", {7'd0, lp_tms[0]}, 8'h01);
        step(T_UPDATE_DR);
        step(T_RUN_IDLE); #1;
        check("R9", "parked idle tms held low", {7'd0, lp_tms[0]}, 8'h00);
        check("R9", "parked tck on", {7'd0, lp_tck_en[0]}, 8'h01);
        check("R12", "port 2 tms follows", {7'd0, lp_tms[1]}, 8'h01);
        bridge_so = 1'b1; #1;
        check("R9", "parked port out of path hi", {7'd0, tdo_out}, 8'h01);
        bridge_so = 1'b0; #1;
        check("R9", "parked port out of path lo", {7'd0, tdo_out}, 8'h00);

        // Park port 3 in test-logic-reset
        load_mode(8'h04);
        @(negedge clk);
        tap_state = T_UPDATE_IR; park_cmd = 1'b1; park_tgt = 2'd3;
        @(negedge clk);
        park_cmd = 1'b0; tap_state = T_EXIT1_IR;
        step(T_UPDATE_IR);
        step(T_RUN_IDLE);
        tms_in = 1'b0; #1;
        check("R9", "parked reset tms held high", {7'd0, lp_tms[2]}, 8'h01);
        check("R9", "port 1 still parked", {7'd0, lp_tms[0]}, 8'h00);

        // Unpark both through update-ir -> select-dr -> run-idle
        @(negedge clk);
        tap_state = T_UPDATE_IR; unpark_cmd = 1'b1; tms_in = 1'b1;
        @(negedge clk);
        unpark_cmd = 1'b0; tap_state = T_SELECT_DR; #1;
        check("R10", "rejoin tms low", {5'd0, lp_tms}, 8'h02);
        check("R10", "rejoin tck on", {5'd0, lp_tck_en}, 8'h05);
        step(T_RUN_IDLE); #1;
        check("R11", "still waiting after select-dr", {5'd0, lp_tms}, 8'h02);
        @(negedge clk); #1;
        check("R11", "synchronised after idle", {5'd0, lp_tms}, 8'h07);
        check("R11", "tck after rejoin", {5'd0, lp_tck_en}, 8'h04);

        // Test-logic-reset clears everything
        load_mode(8'h07);
        @(negedge clk);
        tap_state = T_UPDATE_IR; park_cmd = 1'b1; park_tgt = 2'd1;
        @(negedge clk);
        park_cmd = 1'b0; tap_state = T_EXIT1_DR;
        step(T_UPDATE_DR);
        step(T_RUN_IDLE); #1;
        check("R9", "all parked pause tms low", {5'd0, lp_tms}, 8'h00);
        step(T_RESET);
        step(T_RUN_IDLE); #1;
        check("R1", "tck_en after tlr", {5'd0, lp_tck_en}, 8'h00);
        check("R1", "tms follow after tlr", {5'd0, lp_tms}, 8'h07);
        run_path(8'h00, 0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule